// File: doc/BRIEF.md
# Clock Source Selector with PLL Control Registers

This block decides where a microcontroller's system clock comes from. It can use the crystal reference clock or the multiplied clock from a PLL's VCO. Software talks to it through three byte-wide registers on a small write/read port in the bus clock domain:

- **Control register:** PLL power, source select, interrupt enable and a lock-change flag.
- **Programming register:** the multiplier and VCO range handed to the analog PLL.
- **Bandwidth register:** automatic or manual loop bandwidth, and the synchronized lock status.

The registers enforce an ordering on software. The PLL must be running before the VCO clock may be chosen. The PLL cannot be shut off while its clock is in use. The multiplier settings freeze while the PLL runs.

The chosen source passes through a glitch-free handover built from per-domain synchronizers. It is then halved to form the output clock. A stop request forces the block back to the crystal and turns off both the VCO and the oscillator enable. A monitor-mode input bypasses all of this and routes a fixed alternate clock to the output.

Top module: `clksrc_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x2F, address 1 reads 0x00, address 2 reads 0x66, and address 3 always reads 0x00.
- R2: Address 2 holds the multiplier in bits [7:4] and the VCO range in bits [3:0]. These drive `mul_n` and `vrs_l`. A written nibble of zero leaves that field unchanged.
- R3: A write to address 2 has no effect while the PLL-on bit is 1.
- R4: The select bit (address 0 bit 4) becomes 1 only if PLL-on was already 1 before the write. Select=1 with PLL-on=0 never occurs. A single write of 0x30 from the all-clear state sets only PLL-on.
- R5: A write that clears PLL-on has no effect on that bit while select was 1 before the write, or is being set by the same write.
- R6: Address 0 layout: bit 7 is the interrupt enable (read/write), bit 6 is the flag (read-only), bit 5 is PLL-on, bit 4 is select, and bits [3:0] read as 1.
- R7: `clk_out` runs at half the crystal frequency when select is 0 and at half the VCO frequency when select is 1. The two gated sources are never enabled together.
- R8: While `stop_req` is 1, select is cleared and cannot be set, and `pll_en` and `osc_en` are 0.
- R9: While `mon_mode` is 1, `clk_out` follows `mon_clk` directly.
- R10: Address 1 layout: bit 7 is auto bandwidth (read/write), bit 5 is acquisition/tracking (read/write), and bit 6 is the synchronized `lock_in` when auto is 1 and 0 otherwise. Other bits read as 0.
- R11: In auto mode, any change of the synchronized lock sets the flag. A read of address 0 with `rd_en` clears it. `irq` is 1 exactly when flag, interrupt enable and auto are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock for register access |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag on address 0) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| xtal_clk | input | 1 | Crystal reference clock |
| vco_clk | input | 1 | PLL VCO clock |
| mon_clk | input | 1 | Alternate clock used in monitor mode |
| mon_mode | input | 1 | Forces `clk_out` to `mon_clk` |
| stop_req | input | 1 | Stop-mode request |
| lock_in | input | 1 | Lock indication from the analog PLL |
| clk_out | output | 1 | Half-rate output of the selected clock |
| pll_en | output | 1 | PLL/VCO enable |
| osc_en | output | 1 | Crystal oscillator enable |
| mul_n | output | 4 | Multiplier setting |
| vrs_l | output | 4 | VCO range setting |
| irq | output | 1 | Lock-change interrupt |

## Verification
The hardest case to reach is a single write that attempts an illegal move, for example clearing PLL-on and setting select at once. Such a write is only illegal for particular old register values, so the stimulus table first walks the registers into each old state and then issues the conflicting write. The readback shows which bits moved.

The clock handover is observed by counting `clk_out` edges over a fixed window, after waiting long enough for both synchronizers to settle. The flag path is reached by toggling `lock_in` with auto mode on and then off.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int NIB_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 2'd0,
        ADR_BW   = 2'd1,
        ADR_PROG = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic irq_en;
        logic flag;
        logic pll_on;
        logic sel;
    } ctrl_t;

    typedef struct packed {
        logic [NIB_W-1:0] mul;
        logic [NIB_W-1:0] vrs;
    } prog_t;

    typedef struct packed {
        logic auto_bw;
        logic acq;
    } bw_t;

    localparam ctrl_t CTRL_RST = '{irq_en: 1'b0, flag: 1'b0, pll_on: 1'b1, sel: 1'b0};
    localparam prog_t PROG_RST = '{mul: 4'd6, vrs: 4'd6};
    localparam bw_t   BW_RST   = '{auto_bw: 1'b0, acq: 1'b0};

    function automatic logic [NIB_W-1:0] keep_nonzero(logic [NIB_W-1:0] nw,
                                                      logic [NIB_W-1:0] old);
        return (nw == '0) ? old : nw;
    endfunction

    // Each bit judged against the old state; a new select also pins PLL-on.
    function automatic ctrl_t ctrl_update(ctrl_t old, logic [DATA_W-1:0] wd, logic stop);
        ctrl_t nx;
        nx.irq_en = wd[7];
        nx.flag   = old.flag;
        nx.sel    = wd[4] & old.pll_on & ~stop;
        nx.pll_on = wd[5] | old.sel | nx.sel;
        return nx;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
        return {c.irq_en, c.flag, c.pll_on, c.sel, 4'hF};
    endfunction

endpackage

// File: rtl/clksrc_sync.sv
module clksrc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)            chain[i] <= RST_VAL;
                else if (i == 0)    chain[i] <= d;
                else                chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksrc_regs.sv
module clksrc_regs
    import clksrc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stop_req,
    input  logic              lock_in,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl_q,
    output prog_t             prog_q,
    output bw_t               bw_q,
    output logic              irq
);
    logic lock_s, lock_d;
    logic lock_chg, flag_clr;
    reg_addr_e a;

    assign a = reg_addr_e'(addr);

    clksrc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
        .clk (clk),
        .rst (rst),
        .d   (lock_in),
        .q   (lock_s)
    );

    always_ff @(posedge clk) begin
        if (rst) lock_d <= 1'b0;
        else     lock_d <= lock_s;
    end

    assign lock_chg = bw_q.auto_bw & (lock_s ^ lock_d);
    assign flag_clr = rd_en & (a == ADR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            prog_q <= PROG_RST;
            bw_q   <= BW_RST;
        end else begin
            if (wr_en && a == ADR_CTRL) ctrl_q <= ctrl_update(ctrl_q, wdata, stop_req);
            else if (stop_req)          ctrl_q.sel <= 1'b0;

            if (lock_chg)      ctrl_q.flag <= 1'b1;
            else if (flag_clr) ctrl_q.flag <= 1'b0;

            if (wr_en && a == ADR_PROG && !ctrl_q.pll_on) begin
                prog_q.mul <= keep_nonzero(wdata[7:4], prog_q.mul);
                prog_q.vrs <= keep_nonzero(wdata[3:0], prog_q.vrs);
            end

            if (wr_en && a == ADR_BW) begin
                bw_q.auto_bw <= wdata[7];
                bw_q.acq     <= wdata[5];
            end
        end
    end

    always_comb begin
        unique case (a)
            ADR_CTRL: rdata = ctrl_pack(ctrl_q);
            ADR_BW:   rdata = {bw_q.auto_bw, bw_q.auto_bw & lock_s, bw_q.acq, 5'b0};
            ADR_PROG: rdata = {prog_q.mul, prog_q.vrs};
            default:  rdata = '0;
        endcase
    end

    assign irq = ctrl_q.flag & ctrl_q.irq_en & bw_q.auto_bw;
endmodule

// File: rtl/clksrc_gfmux.sv
module clksrc_gfmux #(
    parameter int STAGES = 2
) (
    input  logic rst,
    input  logic sel,
    input  logic clk_a,
    input  logic clk_b,
    output logic clk_o,
    output logic a_on,
    output logic b_on
);
    logic a_req, b_req, a_s, b_s;

    assign a_req = ~sel & ~b_on;
    assign b_req =  sel & ~a_on;

    clksrc_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync_a (
        .clk (clk_a), .rst (rst), .d (a_req), .q (a_s)
    );
    clksrc_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync_b (
        .clk (clk_b), .rst (rst), .d (b_req), .q (b_s)
    );

    // Enables change only while their clock is low.
    always_ff @(negedge clk_a) begin
        if (rst) a_on <= 1'b1;
        else     a_on <= a_s;
    end

    always_ff @(negedge clk_b) begin
        if (rst) b_on <= 1'b0;
        else     b_on <= b_s;
    end

    assign clk_o = (clk_a & a_on) | (clk_b & b_on);
endmodule

// File: rtl/clksrc_div2.sv
module clksrc_div2 (
    input  logic clk_i,
    input  logic rst,
    output logic clk_o
);
    always_ff @(posedge clk_i) begin
        if (rst) clk_o <= 1'b0;
        else     clk_o <= ~clk_o;
    end
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
    import clksrc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              xtal_clk,
    input  logic              vco_clk,
    input  logic              mon_clk,
    input  logic              mon_mode,
    input  logic              stop_req,
    input  logic              lock_in,
    output logic              clk_out,
    output logic              pll_en,
    output logic              osc_en,
    output logic [NIB_W-1:0]  mul_n,
    output logic [NIB_W-1:0]  vrs_l,
    output logic              irq
);
    ctrl_t ctrl_q;
    prog_t prog_q;
    bw_t   bw_q;
    logic  pll_on_q, sel_q, auto_q;
    logic  mux_clk, xtal_on, vco_on, half_clk;

    clksrc_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .stop_req (stop_req),
        .lock_in  (lock_in),
        .rdata    (rdata),
        .ctrl_q   (ctrl_q),
        .prog_q   (prog_q),
        .bw_q     (bw_q),
        .irq      (irq)
    );

    assign pll_on_q = ctrl_q.pll_on;
    assign sel_q    = ctrl_q.sel;
    assign auto_q   = bw_q.auto_bw;

    clksrc_gfmux #(.STAGES(SYNC_STAGES)) u_mux (
        .rst   (rst),
        .sel   (sel_q),
        .clk_a (xtal_clk),
        .clk_b (vco_clk),
        .clk_o (mux_clk),
        .a_on  (xtal_on),
        .b_on  (vco_on)
    );

    clksrc_div2 u_div (
        .clk_i (mux_clk),
        .rst   (rst),
        .clk_o (half_clk)
    );

    assign clk_out = mon_mode ? mon_clk : half_clk;
    assign pll_en  = pll_on_q & ~stop_req;
    assign osc_en  = ~stop_req;
    assign mul_n   = prog_q.mul;
    assign vrs_l   = prog_q.vrs;
endmodule

// File: rtl/clksrc_ctrl_chk.sv
module clksrc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       stop_req,
    input logic       pll_en,
    input logic       osc_en,
    input logic       irq,
    input logic       pll_on_q,
    input logic       sel_q,
    input logic       auto_q,
    input logic [3:0] mul_n,
    input logic [3:0] vrs_l,
    input logic       xtal_on,
    input logic       vco_on
);
    assert_no_vco_without_pll_R4: assert property (@(posedge clk) disable iff (rst)
        !(sel_q && !pll_on_q));

    assert_pll_held_by_select_R5: assert property (@(posedge clk) disable iff (rst)
        (pll_on_q && sel_q) |=> pll_on_q);

    assert_prog_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        pll_on_q |=> ($stable(mul_n) && $stable(vrs_l)));

    assert_stop_falls_back_R8: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !sel_q);

    assert_stop_gates_R8: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> (!pll_en && !osc_en));

    assert_irq_auto_only_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> auto_q);

    assert_one_source_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xtal_on, vco_on}));
endmodule

bind clksrc_ctrl clksrc_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .stop_req (stop_req),
    .pll_en   (pll_en),
    .osc_en   (osc_en),
    .irq      (irq),
    .pll_on_q (pll_on_q),
    .sel_q    (sel_q),
    .auto_q   (auto_q),
    .mul_n    (mul_n),
    .vrs_l    (vrs_l),
    .xtal_on  (xtal_on),
    .vco_on   (vco_on)
);

// File: tb/clksrc_ctrl_bench.sv
module clksrc_ctrl_bench;
    logic       clk = 1'b0, rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0, rdata;
    logic       xtal_clk = 1'b0, vco_clk = 1'b0, mon_clk = 1'b0;
    logic       mon_mode = 1'b0, stop_req = 1'b0, lock_in = 1'b0;
    logic       clk_out, pll_en, osc_en, irq;
    logic [3:0] mul_n, vrs_l;

    int checks = 0, errors = 0;
    int edges = 0;

    always #2  clk      = ~clk;
    always #10 xtal_clk = ~xtal_clk;
    always #4  vco_clk  = ~vco_clk;
    always #15 mon_clk  = ~mon_clk;

    always @(posedge clk_out) edges++;

    clksrc_ctrl u_clksrc_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .xtal_clk(xtal_clk), .vco_clk(vco_clk),
        .mon_clk(mon_clk), .mon_mode(mon_mode), .stop_req(stop_req),
        .lock_in(lock_in), .clk_out(clk_out), .pll_en(pll_en), .osc_en(osc_en),
        .mul_n(mul_n), .vrs_l(vrs_l), .irq(irq)
    );

    // {addr, wdata, expected readback after the write}
    localparam int NV = 16;
    localparam logic [17:0] VEC [NV] = '{
        {2'd2, 8'h83, 8'h66},  // R3 locked while PLL on after reset
        {2'd0, 8'h00, 8'h0F},  // R6 PLL off, low bits read 1
        {2'd2, 8'h86, 8'h86},  // R2
        {2'd2, 8'h05, 8'h85},  // R2 zero nibble keeps multiplier
        {2'd2, 8'h70, 8'h75},  // R2 zero nibble keeps range
        {2'd0, 8'h30, 8'h2F},  // R4 both from clear: only PLL-on
        {2'd2, 8'h11, 8'h75},  // R3 ignored while PLL on
        {2'd0, 8'h30, 8'h3F},  // R4 select now allowed
        {2'd0, 8'h00, 8'h2F},  // R5 PLL-on held by old select
        {2'd0, 8'h10, 8'h3F},  // R5 clear PLL while setting select: held
        {2'd0, 8'hFF, 8'hBF},  // R6 flag is read-only
        {2'd0, 8'h20, 8'h2F},  // R6 enable and select cleared
        {2'd1, 8'h80, 8'h80},  // R10 auto
        {2'd1, 8'h7F, 8'h20},  // R10 lock bit read-only, acq kept
        {2'd1, 8'h00, 8'h00},  // R10
        {2'd3, 8'hFF, 8'h00}   // R1 unused address
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic count_edges(input int win, output int n);
        int e0;
        e0 = edges;
        #(win);
        n = edges - e0;
    endtask

    task automatic near(input string tag, input int act, input int exp);
        checks++;
        if (act < exp - 1 || act > exp + 1) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, r); check("R1 ctrl", r, 8'h2F);
        rd(2'd1, r); check("R1 bw",   r, 8'h00);
        rd(2'd2, r); check("R1 prog", r, 8'h66);
        check("R2 reset mul", mul_n, 4'd6);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            #1 check($sformatf("table row %0d", i), rdata, VEC[i][7:0]);
        end
        check("R2 mul_n", mul_n, 4'd7);
        check("R2 vrs_l", vrs_l, 4'd5);
        check("R8 pll_en idle", pll_en, 1'b1);

        // R7 crystal source: 20 ns period, halved -> 40 ns
        #400; count_edges(800, n); near("R7 crystal half rate", n, 20);
        wr(2'd0, 8'h30);
        #400; count_edges(800, n); near("R7 vco half rate", n, 50);

        // R8 stop forces crystal and gates enables
        @(negedge clk); stop_req = 1'b1;
        #1 check("R8 pll_en", pll_en, 1'b0);
        check("R8 osc_en", osc_en, 1'b0);
        wr(2'd0, 8'h30);
        #1 check("R8 select blocked", rdata, 8'h2F);
        @(negedge clk); stop_req = 1'b0;
        #400; count_edges(800, n); near("R8 back on crystal", n, 20);

        // R9 monitor override: 30 ns period
        mon_mode = 1'b1;
        #100; count_edges(900, n); near("R9 monitor clock", n, 30);
        mon_mode = 1'b0;

        // R11 flag and interrupt in auto mode
        wr(2'd1, 8'h80);
        wr(2'd0, 8'hA0);
        lock_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd0, r); check("R11 flag set", r, 8'hEF);
        check("R11 irq", irq, 1'b1);
        rd(2'd1, r); check("R10 lock seen", r, 8'hC0);
        @(negedge clk); addr = 2'd0; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        #1 check("R11 flag cleared", rdata, 8'hAF);
        check("R11 irq low", irq, 1'b0);

        // R11 manual mode: lock changes ignored
        wr(2'd1, 8'h00);
        lock_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(2'd0, r); check("R11 no flag in manual", r, 8'hAF);
        lock_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd1, r); check("R10 lock hidden in manual", r, 8'h00);
        check("R11 irq manual", irq, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule